// File: doc/BRIEF.md
# Burst Manchester Deserializer

This receiver takes event words that arrive one at a time on a single serial wire. The wire sits low while no event is being sent. Each event is a burst: two alignment bits, then 32 Manchester-coded data bits, with no clock wire alongside. The block samples the wire with its own clock at four samples per half-bit, after a two-flop synchronizer. A rising edge on the idle wire starts a burst, so the block locks on the first bit. From then on, each mid-bit transition sets the timing window in which the next one is expected.

When all 32 data bits are in, the word is shown on a parallel output with a valid/ready handshake. After the consumer takes the word, the block raises its link acknowledge line toward the transmitter. It holds that line high until the transmitter drops its link request. This gives the next event on the link a clean start.

Top module: `man_burst_rx`

## Requirements
- R1: While rst_ni is low, out_valid_o, link_ack_o and err_o are 0 and data_o is all zeros.
- R2: A bit cell lasts two half-bits of 4 clocks each. A falling transition at mid-cell decodes as 1 and a rising one as 0. The first data bit received becomes data_o[31] and the last becomes data_o[0].
- R3: A burst starts with a rising edge on the low idle line. The first alignment bit must decode as 1 and the second as 0. If they do not, the burst is dropped: no word is produced, no error is flagged, and the block waits for a new start edge.
- R4: A mid-cell transition is accepted from 6 to 14 clocks after the previous accepted one. Transitions seen earlier than 6 clocks are cell-boundary edges and are ignored. Bursts whose half-bits vary between 3 and 5 clocks therefore decode correctly.
- R5: If no mid-cell transition arrives by 14 clocks after the last accepted one, err_o goes high for exactly one cycle. The partial word is discarded, and the block hunts for a new burst.
- R6: After the 32nd data bit, out_valid_o rises and stays high, with data_o unchanged, until out_ready_i is sampled high.
- R7: link_ack_o rises in the cycle after out_valid_o and out_ready_i are both high. It stays high while the synchronized link_req_i is high, and falls on the third clock edge after link_req_i goes low. out_valid_o and link_ack_o are never high together.
- R8: While out_valid_o or link_ack_o is high, the serial input is ignored: data_o holds and err_o stays low.
- R9: A burst that starts after a dropped burst, an error or a released acknowledge is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| serial_i | input | 1 | Serial line, idle low |
| link_req_i | input | 1 | Link request from the transmitter (asynchronous) |
| link_ack_o | output | 1 | Link acknowledge to the transmitter |
| data_o | output | 32 | Received word |
| out_valid_o | output | 1 | Word available |
| out_ready_i | input | 1 | Consumer accepts the word |
| err_o | output | 1 | One-cycle pulse on a missing mid-cell transition |

## Verification
The assertions assume three things about the inputs. The consumer may hold out_ready_i at any level. link_req_i is only looked at through its synchronized copy. The serial line is low between bursts. The stimulus keeps every half-bit between 3 and 5 clocks, except where a missing transition is wanted on purpose. It always returns the line to low after a burst, so no stray rising edge can start a false burst.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  typedef enum logic {ST_HUNT, ST_RX} rx_state_e;
endpackage

// File: rtl/mbr_sync.sv
module mbr_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/mbr_bit_timer.sv
module mbr_bit_timer #(
  parameter int OSR = 4,
  parameter int TOL = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic run_i,
  input  logic edge_i,
  input  logic lvl_prev_i,
  output logic bit_stb_o,
  output logic bit_o,
  output logic tmo_o
);
  localparam int BIT_CLKS = 2 * OSR;
  localparam int WIN_LO   = BIT_CLKS - OSR / 2;
  localparam int WIN_HI   = BIT_CLKS + TOL;
  localparam int CW       = $clog2(WIN_HI + 2);

  logic [CW-1:0] cnt_q;
  logic in_win, late;

  assign in_win    = cnt_q >= CW'(WIN_LO);
  assign late      = cnt_q >= CW'(WIN_HI);
  assign bit_stb_o = run_i & edge_i & in_win;
  assign bit_o     = lvl_prev_i;           // high before the edge -> falling -> 1
  assign tmo_o     = run_i & late & ~bit_stb_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (arm_i)     cnt_q <= CW'(OSR + 1); // start edge is a cell boundary
    else if (run_i) begin
      if (bit_stb_o)    cnt_q <= CW'(1);
      else if (!late)   cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/mbr_handshake.sv
module mbr_handshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic ready_i,
  input  logic req_i,
  output logic valid_o,
  output logic ack_o,
  output logic busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ack_o   <= 1'b0;
    end else begin
      if (done_i)                valid_o <= 1'b1;
      else if (valid_o & ready_i) valid_o <= 1'b0;
      if (valid_o & ready_i)     ack_o <= 1'b1;
      else if (ack_o & ~req_i)   ack_o <= 1'b0;
    end
  end
  assign busy_o = valid_o | ack_o;
endmodule

// File: rtl/man_burst_rx.sv
module man_burst_rx
  import mbr_pkg::*;
#(
  parameter int              DATA_W  = 32,
  parameter int              PRE_W   = 2,
  parameter logic [PRE_W-1:0] PRE_PAT = 2'b10,
  parameter int              OSR     = 4,
  parameter int              TOL     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              serial_i,
  input  logic              link_req_i,
  output logic              link_ack_o,
  output logic [DATA_W-1:0] data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              err_o
);
  localparam int TOTAL = PRE_W + DATA_W;
  localparam int BCW   = $clog2(TOTAL + 1);

  logic              rx_s, req_s, rx_d;
  logic              rise, edge_x, arm, run;
  logic              bit_stb, bit_val, tmo, done, busy;
  rx_state_e         state_q;
  logic [BCW-1:0]    bitcnt_q;
  logic [PRE_W-1:0]  pre_q;
  logic [DATA_W-1:0] shreg_q;
  logic              err_q;

  mbr_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({link_req_i, serial_i}),
    .q_o   ({req_s, rx_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_d <= 1'b0;
    else         rx_d <= rx_s;
  end

  assign rise   = rx_s & ~rx_d;
  assign edge_x = rx_s ^ rx_d;
  assign run    = (state_q == ST_RX);
  assign arm    = (state_q == ST_HUNT) & ~busy & rise;

  mbr_bit_timer #(.OSR(OSR), .TOL(TOL)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm),
    .run_i     (run),
    .edge_i    (edge_x),
    .lvl_prev_i(rx_d),
    .bit_stb_o (bit_stb),
    .bit_o     (bit_val),
    .tmo_o     (tmo)
  );

  assign done = run & bit_stb & (bitcnt_q == BCW'(TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      bitcnt_q <= '0;
      pre_q    <= '0;
      shreg_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= tmo;
      if (arm) begin
        state_q  <= ST_RX;
        bitcnt_q <= '0;
        pre_q    <= PRE_PAT;
        shreg_q  <= '0;
      end else if (run) begin
        if (tmo) begin
          state_q <= ST_HUNT;
          shreg_q <= '0;
        end else if (bit_stb) begin
          bitcnt_q <= bitcnt_q + BCW'(1);
          if (bitcnt_q < BCW'(PRE_W)) begin
            pre_q <= pre_q << 1;
            if (bit_val != pre_q[PRE_W-1]) state_q <= ST_HUNT; // misaligned burst
          end else begin
            shreg_q <= {shreg_q[DATA_W-2:0], bit_val};
            if (done) state_q <= ST_HUNT;
          end
        end
      end
    end
  end

  mbr_handshake u_hs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (done),
    .ready_i(out_ready_i),
    .req_i  (req_s),
    .valid_o(out_valid_o),
    .ack_o  (link_ack_o),
    .busy_o (busy)
  );

  assign data_o = shreg_q;
  assign err_o  = err_q;
endmodule

// File: rtl/man_burst_rx_chk.sv
module man_burst_rx_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] data_o,
  input logic              link_ack_o,
  input logic              req_s,
  input logic              err_o
);
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(data_o)); // R6
  AST_ACK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i |=> link_ack_o && !out_valid_o); // R7
  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_ack_o && req_s |=> link_ack_o); // R7
  AST_ACK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_valid_o && link_ack_o)); // R7
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R5
  AST_BUSY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o || link_ack_o) |-> !err_o); // R8
endmodule

bind man_burst_rx man_burst_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .data_o     (data_o),
  .link_ack_o (link_ack_o),
  .req_s      (req_s),
  .err_o      (err_o)
);

// File: tb/man_burst_rx_bench.sv
`timescale 1ns/1ps
module man_burst_rx_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        serial = 1'b0;
  logic        req = 1'b0;
  logic        ready = 1'b0;
  logic        ack, valid, err;
  logic [31:0] data;
  int          checks = 0;
  int          errors = 0;
  int          err_seen = 0;

  always #2.5 clk = ~clk;

  man_burst_rx u_man_burst_rx (
    .clk_i(clk), .rst_ni(rst_ni), .serial_i(serial), .link_req_i(req),
    .link_ack_o(ack), .data_o(data), .out_valid_o(valid),
    .out_ready_i(ready), .err_o(err)
  );

  always @(negedge clk) if (err) err_seen++;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input int h1, input int h2);
    serial = b;  idle(h1);
    serial = ~b; idle(h2);
  endtask

  // pre: alignment bits, first sent = pre[1]; nbits data bits MSB first
  task automatic send_burst(input bit [1:0] pre, input logic [31:0] w,
                            input int nbits, input bit jit);
    for (int i = 0; i < 2 + nbits; i++) begin
      bit b;
      int a, c;
      b = (i < 2) ? pre[1-i] : w[31-(i-2)];
      a = jit ? ((i % 2) ? 5 : 3) : 4;
      c = jit ? ((i % 2) ? 3 : 5) : 4;
      send_bit(b, a, c);
    end
    serial = 1'b0;
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // receive a word, hand it off and release the link
  task automatic take_word(input logic [31:0] exp, input string tag);
    bit got;
    wait_valid(got);
    check(got, {tag, " valid"}, got, 1);
    check(data == exp, {tag, " data"}, data, exp);
    check(!ack, {tag, " no ack before ready R7"}, ack, 0);
    ready = 1'b1; @(negedge clk); ready = 1'b0;
    check(ack && !valid, {tag, " ack after ready R7"}, {ack, valid}, 2'b10);
    req = 1'b0; idle(2);
    check(ack, "R7 ack held during req sync", ack, 1);
    idle(1);
    check(!ack, "R7 ack released", ack, 0);
    idle(4);
  endtask

  task automatic t_reset;
    check(!valid && !ack && !err && data == 0, "R1 reset state",
          {valid, ack, err, data}, 0);
  endtask

  task automatic t_basic(input logic [31:0] w, input string tag);
    req = 1'b1;
    send_burst(2'b10, w, 32, 1'b0);
    take_word(w, tag);
  endtask

  task automatic t_hold;
    logic [31:0] w0;
    req = 1'b1;
    send_burst(2'b10, 32'h1357_9BDF, 32, 1'b0);
    idle(20);
    w0 = data;
    check(valid, "R6 valid pending", valid, 1);
    idle(10);
    check(valid && data == w0, "R6 held without ready", data, w0);
    // R8: a second burst while the word is pending must be ignored
    begin
      int e0;
      e0 = err_seen;
      send_burst(2'b10, 32'hFFFF_0000, 32, 1'b0);
      idle(20);
      check(valid && data == 32'h1357_9BDF, "R8 burst ignored while busy", data, 32'h1357_9BDF);
      check(err_seen == e0, "R8 no error while busy", err_seen, e0);
    end
    take_word(32'h1357_9BDF, "R6 hold");
  endtask

  task automatic t_bad_pre;
    int e0;
    e0 = err_seen;
    req = 1'b1;
    send_burst(2'b11, 32'h0, 0, 1'b0);
    idle(30);
    check(!valid, "R3 bad alignment no word", valid, 0);
    check(err_seen == e0, "R3 bad alignment no error", err_seen, e0);
    t_basic(32'h0F0F_1234, "R9 after drop");
  endtask

  task automatic t_timeout;
    int e0;
    e0 = err_seen;
    req = 1'b1;
    send_burst(2'b10, 32'hA000_0000, 5, 1'b0);
    idle(30);
    check(err_seen == e0 + 1, "R5 single error pulse", err_seen, e0 + 1);
    check(!valid, "R5 partial word discarded", valid, 0);
    t_basic(32'h8000_0001, "R9 after error");
  endtask

  task automatic t_jitter;
    req = 1'b1;
    send_burst(2'b10, 32'hC3A5_5A3C, 32, 1'b1);
    take_word(32'hC3A5_5A3C, "R4 jittered halves");
  endtask

  initial begin
    idle(3);
    t_reset();
    rst_ni = 1'b1;
    idle(5);
    t_basic(32'hA5A5_F00F, "R2 mixed");
    t_basic(32'hFFFF_FFFF, "R2 ones");
    t_basic(32'h0000_0000, "R2 zeros");
    t_hold();
    t_bad_pre();
    t_timeout();
    t_jitter();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule